// File: doc/BRIEF.md
# Parity-Checked Channel Input Node

This block is the receiving end of one data channel in a multi-channel formatter. A sender presents a 32-bit word together with a single parity bit and a valid strobe. The node answers with a wait signal, which is the inverse of a ready: while wait is low the node takes the word on the next rising clock edge. While wait is high the sender must hold its word and its valid strobe. Accepted words are placed in a small first-in first-out store. A downstream arbiter drains that store through a show-ahead pop port that also reports emptiness and the current fill level.

Each accepted word is checked against its parity bit as it arrives. The expected bit is the XOR of all 32 data bits. When the two disagree, the node raises its parity-error output for one cycle. The word is kept anyway, so the number of stored words always equals the number of completed handshakes. A system uses one node for each channel.

Reset is synchronous and active high. It empties the store, holds wait low and clears the error output. The wait output comes straight from a register, so it has no combinational path from valid.

Top module: `parity_chan_node`

## Requirements
- R1: After reset, rd_empty is 1, rd_count is 0, in_wait is 0 and in_perr is 0.
- R2: A word is accepted on a rising edge where in_valid is 1 and in_wait is 0. Without a pop on that edge, rd_count rises by exactly one.
- R3: in_wait is 1 exactly when rd_count equals DEPTH. It falls in the cycle after a pop from a full store.
- R4: A word offered while in_wait is 1 is not stored. rd_count and the word order at rd_data are unchanged.
- R5: One cycle after an accepting edge, in_perr is 1 if in_par differed from the XOR of all bits of in_data, and 0 otherwise. It stays high for one cycle only, unless the next accepted word also fails.
- R6: A word with bad parity is still stored, and it is later read back with its original data.
- R7: rd_data shows the oldest stored word. A pop with rd_empty at 0 removes that word, so words leave in the order they arrived.
- R8: A pop while rd_empty is 1 has no effect. rd_count stays 0, and the next stored word appears correctly at rd_data.
- R9: An accept and a pop on the same edge leave rd_count unchanged.
- R10: rd_empty is 1 exactly when rd_count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 32 | Incoming data word |
| in_par | input | 1 | Parity bit sent with in_data (XOR of its bits) |
| in_valid | input | 1 | Sender has a word on in_data |
| in_wait | output | 1 | Node cannot take a word this cycle |
| in_perr | output | 1 | One-cycle flag: the last accepted word failed its parity check |
| rd_pop | input | 1 | Consumer removes the word at rd_data |
| rd_data | output | 32 | Oldest stored word (show-ahead) |
| rd_empty | output | 1 | Store holds no word |
| rd_count | output | $clog2(DEPTH+1) | Number of stored words |

## Verification
The bench builds the node with DEPTH set to 4. With that depth the full condition is reached after four handshakes. This makes it possible to test the wait assertion, refused offers while full, release after one pop, and pointer wrap-around in a few dozen cycles. The default depth of 32 is used only for elaboration. The data width comes from the package and stays at 32, so the parity check is exercised on full-width words with both odd and even bit counts.

// File: rtl/chnode_pkg.sv
package chnode_pkg;

    localparam int WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t data;
        logic  par;
    } beat_t;

    // Expected parity bit: XOR reduction of every data bit
    function automatic logic calc_parity(input word_t d);
        return ^d;
    endfunction

endpackage

// File: rtl/chnode_par_chk.sv
module chnode_par_chk
    import chnode_pkg::*;
(
    input  beat_t beat_i,
    output logic  bad_o
);

    logic expect_par;

    always_comb begin
        expect_par = calc_parity(beat_i.data);
        bad_o      = expect_par ^ beat_i.par;
    end

endmodule

// File: rtl/chnode_fifo.sv
module chnode_fifo
    import chnode_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  word_t            wdata_i,
    input  logic             pop_i,
    output word_t            rdata_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_nxt_o
);

    word_t            mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] cnt;
    logic             do_push;
    logic             do_pop;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        do_push = push_i && (cnt != CNT_W'(DEPTH));
        do_pop  = pop_i && (cnt != '0);
        unique case ({do_push, do_pop})
            2'b10:   cnt_nxt_o = cnt + CNT_W'(1);
            2'b01:   cnt_nxt_o = cnt - CNT_W'(1);
            default: cnt_nxt_o = cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
            cnt <= cnt_nxt_o;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata_i;
    end

    assign rdata_o = mem[rd_ptr];
    assign cnt_o   = cnt;

endmodule

// File: rtl/parity_chan_node.sv
module parity_chan_node
    import chnode_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [31:0]      in_data,
    input  logic             in_par,
    input  logic             in_valid,
    output logic             in_wait,
    output logic             in_perr,
    input  logic             rd_pop,
    output logic [31:0]      rd_data,
    output logic             rd_empty,
    output logic [CNT_W-1:0] rd_count
);

    beat_t            beat;
    logic             beat_bad;
    logic             accept;
    logic             wait_q;
    logic             perr_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;
    word_t            head;

    assign beat   = '{data: in_data, par: in_par};
    assign accept = in_valid && !wait_q;

    chnode_par_chk u_par (
        .beat_i (beat),
        .bad_o  (beat_bad)
    );

    chnode_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push_i    (accept),
        .wdata_i   (beat.data),
        .pop_i     (rd_pop),
        .rdata_o   (head),
        .cnt_o     (cnt),
        .cnt_nxt_o (cnt_nxt)
    );

    // Backpressure and error flag are both registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q <= 1'b0;
            perr_q <= 1'b0;
        end else begin
            wait_q <= (cnt_nxt == CNT_W'(DEPTH));
            perr_q <= accept && beat_bad;
        end
    end

    assign in_wait  = wait_q;
    assign in_perr  = perr_q;
    assign rd_data  = head;
    assign rd_count = cnt;
    assign rd_empty = (cnt == '0);

endmodule

module parity_chan_node_chk #(
    parameter int DEPTH = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_wait,
    input logic             in_perr,
    input logic             rd_pop,
    input logic             rd_empty,
    input logic [CNT_W-1:0] rd_count
);

    p_wait_full_r3: assert property (@(posedge clk) disable iff (rst)
        in_wait == (rd_count == CNT_W'(DEPTH)));

    p_empty_flag_r10: assert property (@(posedge clk) disable iff (rst)
        rd_empty == (rd_count == '0));

    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_wait && !rd_pop) |=> (rd_count == $past(rd_count) + CNT_W'(1)));

    p_refused_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_wait && !rd_pop) |=> (rd_count == $past(rd_count)));

    p_perr_cause_r5: assert property (@(posedge clk) disable iff (rst)
        in_perr |-> $past(in_valid && !in_wait));

    p_pop_empty_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_pop && rd_empty && !in_valid) |=> (rd_count == '0));

    p_push_pop_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_wait && rd_pop && !rd_empty) |=> (rd_count == $past(rd_count)));

endmodule

bind parity_chan_node parity_chan_node_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_wait  (in_wait),
    .in_perr  (in_perr),
    .rd_pop   (rd_pop),
    .rd_empty (rd_empty),
    .rd_count (rd_count)
);

// File: tb/tb_parity_chan_node.sv
module tb_parity_chan_node;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam int CNT_W      = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [31:0]      in_data = '0;
    logic             in_par = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_wait;
    logic             in_perr;
    logic             rd_pop = 1'b0;
    logic [31:0]      rd_data;
    logic             rd_empty;
    logic [CNT_W-1:0] rd_count;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    parity_chan_node #(.DEPTH(DEPTH)) dut (
        .clk      (clk),
        .rst      (rst),
        .in_data  (in_data),
        .in_par   (in_par),
        .in_valid (in_valid),
        .in_wait  (in_wait),
        .in_perr  (in_perr),
        .rd_pop   (rd_pop),
        .rd_data  (rd_data),
        .rd_empty (rd_empty),
        .rd_count (rd_count)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Offer one word for one cycle; good selects correct parity
    task automatic push_word(input logic [31:0] d, input bit good);
        in_valid = 1'b1;
        in_data  = d;
        in_par   = good ? ^d : ~(^d);
        cyc();
        in_valid = 1'b0;
    endtask

    task automatic pop_word();
        rd_pop = 1'b1;
        cyc();
        rd_pop = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        cyc();
        cyc();
        rst = 1'b0;
        check(rd_empty == 1'b1, "R1 empty", 32'(rd_empty), 32'd1);
        check(rd_count == 0, "R1 count", 32'(rd_count), 32'd0);
        check(in_wait == 1'b0, "R1 wait", 32'(in_wait), 32'd0);
        check(in_perr == 1'b0, "R1 perr", 32'(in_perr), 32'd0);
    endtask

    task automatic t_push_pop_order();
        logic [31:0] w [3] = '{32'h1234_5678, 32'h0000_0001, 32'hFFFF_0000};
        for (int i = 0; i < 3; i++) begin
            push_word(w[i], 1'b1);
            check(rd_count == CNT_W'(i + 1), "R2 count step", 32'(rd_count), 32'(i + 1));
            check(in_perr == 1'b0, "R5 good parity no flag", 32'(in_perr), 32'd0);
        end
        check(rd_empty == 1'b0, "R10 not empty", 32'(rd_empty), 32'd0);
        for (int i = 0; i < 3; i++) begin
            check(rd_data == w[i], "R7 order", rd_data, w[i]);
            pop_word();
        end
        check(rd_empty == 1'b1 && rd_count == 0, "R7 drained", 32'(rd_count), 32'd0);
    endtask

    task automatic t_bad_parity();
        push_word(32'hA5A5_0007, 1'b0);
        check(in_perr == 1'b1, "R5 bad parity flagged", 32'(in_perr), 32'd1);
        check(rd_count == 1, "R6 bad word stored", 32'(rd_count), 32'd1);
        cyc();
        check(in_perr == 1'b0, "R5 single-cycle pulse", 32'(in_perr), 32'd0);
        check(rd_data == 32'hA5A5_0007, "R6 bad word data", rd_data, 32'hA5A5_0007);
        pop_word();
    endtask

    task automatic t_full();
        for (int i = 0; i < DEPTH; i++) begin
            check(in_wait == 1'b0, "R3 wait low before full", 32'(in_wait), 32'd0);
            push_word(32'hC000_0000 + 32'(i), 1'b1);
        end
        check(in_wait == 1'b1, "R3 wait high when full", 32'(in_wait), 32'd1);
        in_valid = 1'b1;
        in_data  = 32'hDEAD_BEEF;
        in_par   = ^in_data;
        cyc();
        cyc();
        in_valid = 1'b0;
        check(rd_count == CNT_W'(DEPTH), "R4 refused count", 32'(rd_count), 32'(DEPTH));
        check(in_perr == 1'b0, "R4 refused no flag", 32'(in_perr), 32'd0);
        pop_word();
        check(in_wait == 1'b0, "R3 wait released", 32'(in_wait), 32'd0);
        for (int i = 1; i < DEPTH; i++) begin
            check(rd_data == 32'hC000_0000 + 32'(i), "R4 order intact", rd_data, 32'hC000_0000 + 32'(i));
            pop_word();
        end
        check(rd_empty == 1'b1, "R4 no extra word", 32'(rd_empty), 32'd1);
    endtask

    task automatic t_pop_empty();
        pop_word();
        pop_word();
        check(rd_count == 0, "R8 pop empty count", 32'(rd_count), 32'd0);
        push_word(32'h0BAD_F00D, 1'b1);
        check(rd_count == 1, "R8 count after push", 32'(rd_count), 32'd1);
        check(rd_data == 32'h0BAD_F00D, "R8 head after push", rd_data, 32'h0BAD_F00D);
    endtask

    task automatic t_simul();
        in_valid = 1'b1;
        in_data  = 32'h7777_1111;
        in_par   = ^in_data;
        rd_pop   = 1'b1;
        cyc();
        in_valid = 1'b0;
        rd_pop   = 1'b0;
        check(rd_count == 1, "R9 count kept", 32'(rd_count), 32'd1);
        check(rd_data == 32'h7777_1111, "R9 new head", rd_data, 32'h7777_1111);
        pop_word();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_push_pop_order();
        t_bad_parity();
        t_full();
        t_pop_empty();
        t_simul();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule